// File: doc/BRIEF.md
# Private Reload Timer With Interrupt

A down-counting timer meant to sit beside a single core. Software programs a load value, then turns the timer on through a control register. The counter steps down once every `prescale + 1` clock cycles. When it reaches zero it raises an event flag, and it either holds at zero (one-shot) or refills from the load value (periodic). The interrupt line is the event flag masked by an interrupt-enable bit in the control register. Software acknowledges the event by writing a one to the status register.

A control write that sets the enable bit behaves in one of two ways. If the timer is already running with a nonzero count, the write does not disturb the count or the prescale phase. Otherwise the counting restarts, and the counter refills from the load value when periodic mode is selected. A control write that clears the enable bit freezes the counter at the same clock edge.

The register bus is a simple word-addressed strobe interface. Writes take effect at the clock edge where `wr_i` is sampled. A read returns its data one cycle after `rd_i`, with `rvalid_o` high.

Top module: `prt_timer`

## Requirements
- R1: After reset the load, counter, control and status registers all read 0, and `irq_o` is low.
- R2: The registers sit at byte offsets 0 (load), 4 (counter), 8 (control) and 12 (status). Any access whose two low address bits are nonzero has no effect. A write to the load register sets both the load and the counter. A write to the counter register sets only the counter. A read samples the register at the edge where `rd_i` is high and presents it on `rdata_o` with `rvalid_o` high during the following cycle.
- R3: While the timer is enabled (control bit 0), the counter decrements by one on each prescaled tick. The tick that takes the counter from 1 to its end value sets status bit 0 at the same edge.
- R4: In one-shot mode (control bit 1 = 0), the counter stays at 0 after reaching zero while the timer remains enabled.
- R5: `irq_o` equals status bit 0 AND control bit 2, combinationally. A control write that changes bit 2 changes `irq_o` right after that edge.
- R6: Writing status with bit 0 = 1 clears the event flag. Writing status with bit 0 = 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R7: In periodic mode (control bit 1 = 1), the tick that ends a period loads the counter from the load register instead of leaving 0.
- R8: A control write with bit 0 = 1, made while the timer is enabled and the counter is nonzero, neither reloads the counter nor restarts the prescaler. Counting continues, including the tick at that edge.
- R9: A control write with bit 0 = 0 stops counting at that edge. The counter holds its value until the next restart or bus write.
- R10: A control write with bit 0 = 1, made while the timer is stopped or the counter is 0, restarts the prescale phase. It loads the counter from the load register if the written bit 1 is 1, and keeps the counter value if bit 1 is 0.
- R11: Control bits 15:8 hold a prescale value P. After a start, the first decrement comes P+1 cycles after the starting edge, and every following decrement comes P+1 cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_i |
| irq_o | output | 1 | Level interrupt |

## Verification
A write lands at the edge after the bench drives it, and `irq_o` follows that edge in the same cycle. A read returns the register value from just before the edge that samples `rd_i`, and it appears one cycle later. With prescale P, the counter reaches zero L·(P+1) edges after the enabling edge, counting from that edge. The bench drives all inputs on falling edges and pushes each read's expected value into a queue when it issues the read. A falling-edge monitor pops and compares an entry whenever `rvalid_o` is high. Interrupt checks sample at the falling edge just before and just after the computed zero-crossing edge, so an off-by-one in either the prescaler or the counter is visible.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_AUTO   = 1;
  localparam int unsigned CB_IRQ    = 2;
  localparam int unsigned CB_PS_LSB = 8;

  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_STAT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/prt_presc.sv
module prt_presc #(
  parameter int unsigned PSW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           restart_i,
  input  logic [PSW-1:0] div_i,
  output logic           tick_o
);
  logic [PSW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (cnt_q == div_i)      cnt_q <= '0;
    else                          cnt_q <= cnt_q + PSW'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && !restart_i) |=> (!tick_o || div_i == '0)); // R11
endmodule

// File: rtl/prt_count.sv
module prt_count import prt_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          auto_i,
  input  logic [DW-1:0] load_i,
  input  logic          load_wr_i,
  input  logic          cnt_wr_i,
  input  logic          ctrl_wr_i,
  input  logic          stat_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] count_o,
  output logic          evt_o,
  output logic          restart_o
);
  logic [DW-1:0] count_q;
  logic          evt_q;
  logic          start, stop, hit_end, quiet;

  assign start   = ctrl_wr_i && wdata_i[CB_EN] && !(en_i && count_q != '0);
  assign stop    = ctrl_wr_i && !wdata_i[CB_EN];
  assign quiet   = !(load_wr_i || cnt_wr_i || ctrl_wr_i);
  // ignored enable write still lets the pending tick through
  assign hit_end = tick_i && count_q == DW'(1) && !load_wr_i && !cnt_wr_i && !start && !stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (load_wr_i || cnt_wr_i) begin
      count_q <= wdata_i;
    end else if (start) begin
      if (wdata_i[CB_AUTO]) count_q <= load_i;
    end else if (stop) begin
      count_q <= count_q;
    end else if (tick_i && count_q != '0) begin
      if (count_q == DW'(1)) count_q <= auto_i ? load_i : '0;
      else                   count_q <= count_q - DW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      evt_q <= 1'b0;
    else if (hit_end)                 evt_q <= 1'b1;
    else if (stat_wr_i && wdata_i[0]) evt_q <= 1'b0;
  end

  assign count_o   = count_q;
  assign evt_o     = evt_q;
  assign restart_o = start;

  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_q > DW'(1) && quiet) |=> (count_q == $past(count_q) - DW'(1))); // R3
  AST_END_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_q == DW'(1) && quiet) |=> evt_q); // R3
  AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && !auto_i && quiet) |=> (count_q == '0)); // R4
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && auto_i && count_q == DW'(1) && quiet) |=> (count_q == $past(load_i))); // R7
  AST_RUN_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && wdata_i[CB_EN] && en_i && count_q != '0 && !tick_i) |=> $stable(count_q)); // R8
  AST_STOP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && quiet) |=> $stable(count_q)); // R9
endmodule

// File: rtl/prt_timer.sv
module prt_timer import prt_pkg::*; #(
  parameter int unsigned DW  = 32,
  parameter int unsigned PSW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [3:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          irq_o
);
  localparam int unsigned CTRL_W = CB_PS_LSB + PSW;

  reg_sel_e       sel;
  logic           hit;
  logic           load_wr, cnt_wr, ctrl_wr, stat_wr;
  logic [DW-1:0]  load_q, count, ctrl_rd, rd_mux, rdata_q;
  logic           en_q, auto_q, irqen_q, rvalid_q;
  logic [PSW-1:0] ps_q;
  logic           tick, evt, restart;

  assign sel     = reg_sel_e'(addr_i[3:2]);
  assign hit     = addr_i[1:0] == 2'b00;
  assign load_wr = wr_i && hit && sel == SEL_LOAD;
  assign cnt_wr  = wr_i && hit && sel == SEL_COUNT;
  assign ctrl_wr = wr_i && hit && sel == SEL_CTRL;
  assign stat_wr = wr_i && hit && sel == SEL_STAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q  <= '0;
      en_q    <= 1'b0;
      auto_q  <= 1'b0;
      irqen_q <= 1'b0;
      ps_q    <= '0;
    end else begin
      if (load_wr) load_q <= wdata_i;
      if (ctrl_wr) begin
        en_q    <= wdata_i[CB_EN];
        auto_q  <= wdata_i[CB_AUTO];
        irqen_q <= wdata_i[CB_IRQ];
        ps_q    <= wdata_i[CB_PS_LSB +: PSW];
      end
    end
  end

  always_comb begin
    ctrl_rd                     = '0;
    ctrl_rd[CB_EN]              = en_q;
    ctrl_rd[CB_AUTO]            = auto_q;
    ctrl_rd[CB_IRQ]             = irqen_q;
    ctrl_rd[CB_PS_LSB +: PSW]   = ps_q;
    rd_mux = '0;
    if (hit) begin
      unique case (sel)
        SEL_LOAD:  rd_mux = load_q;
        SEL_COUNT: rd_mux = count;
        SEL_CTRL:  rd_mux = ctrl_rd;
        SEL_STAT:  rd_mux = DW'(evt);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      if (rd_i) rdata_q <= rd_mux;
    end
  end

  prt_presc #(.PSW(PSW)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (en_q),
    .restart_i (restart),
    .div_i     (ps_q),
    .tick_o    (tick)
  );

  prt_count #(.DW(DW)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .en_i      (en_q),
    .auto_i    (auto_q),
    .load_i    (load_q),
    .load_wr_i (load_wr),
    .cnt_wr_i  (cnt_wr),
    .ctrl_wr_i (ctrl_wr),
    .stat_wr_i (stat_wr),
    .wdata_i   (wdata_i),
    .count_o   (count),
    .evt_o     (evt),
    .restart_o (restart)
  );

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = evt && irqen_q;

  initial assert (DW > CTRL_W); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irqen_q |-> !irq_o); // R5
  AST_READ_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o); // R2
  AST_NO_SPUR_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o); // R2
endmodule

// File: tb/tb_prt_timer.sv
module tb_prt_timer;
  localparam int unsigned DW = 32;
  localparam logic [3:0] A_LOAD = 4'd0, A_CNT = 4'd4, A_CTRL = 4'd8, A_STAT = 4'd12;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } rd_item_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_i = 1'b0, rd_i = 1'b0;
  logic [3:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  rd_item_t sb[$];

  always #10 clk = ~clk;

  prt_timer #(.DW(DW), .PSW(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .irq_o(irq_o)
  );

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [DW-1:0] e, input string tag);
    rd_i = 1'b1; addr_i = a;
    sb.push_back('{exp: e, tag: tag});
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s irq_o actual %0b expected %0b", tag, irq_o, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (rst_ni && rvalid_o) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected read data actual %0h expected none", rdata_o);
      end else begin
        rd_item_t it;
        it = sb.pop_front();
        if (rdata_o !== it.exp) begin
          errors++;
          $display("FAIL %s read actual %0h expected %0h", it.tag, rdata_o, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(A_LOAD, 0, "R1 load");
    rd(A_CNT,  0, "R1 count");
    rd(A_CTRL, 0, "R1 ctrl");
    rd(A_STAT, 0, "R1 status");

    // R2 load writes counter, counter write alone, misaligned ignored
    wr(A_LOAD, 32'd5);
    rd(A_CNT, 32'd5, "R2 load->count");
    wr(A_CNT, 32'd3);
    rd(A_CNT, 32'd3, "R2 count write");
    rd(A_LOAD, 32'd5, "R2 load kept");
    wr(4'd1, 32'hFF);
    rd(A_LOAD, 32'd5, "R2 misaligned ignored");

    // R3/R4 one-shot, P=0, load 4
    wr(A_LOAD, 32'd4);
    wr(A_CTRL, 32'h5);
    idle(3);
    chk_irq(1'b0, "R3 before zero");
    idle(1);
    chk_irq(1'b1, "R3 at zero");
    rd(A_CNT, 32'd0, "R4 count at zero");
    rd(A_STAT, 32'd1, "R3 status set");
    idle(3);
    rd(A_CNT, 32'd0, "R4 one-shot holds");

    // R5 irq gating
    wr(A_CTRL, 32'h1);
    chk_irq(1'b0, "R5 masked");
    rd(A_STAT, 32'd1, "R5 status still set");
    wr(A_CTRL, 32'h5);
    chk_irq(1'b1, "R5 unmasked");

    // R6 write-one-to-clear
    wr(A_STAT, 32'd0);
    chk_irq(1'b1, "R6 write zero no effect");
    rd(A_STAT, 32'd1, "R6 status kept");
    wr(A_STAT, 32'd1);
    chk_irq(1'b0, "R6 cleared");
    rd(A_STAT, 32'd0, "R6 status cleared");

    // R7 periodic reload
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, 32'h7);
    idle(3);
    chk_irq(1'b1, "R7 event in periodic");
    rd(A_CNT, 32'd3, "R7 reloaded");

    // R8 enable write while running: no reload
    wr(A_CTRL, 32'h7);
    rd(A_CNT, 32'd1, "R8 no reload while running");

    // R9 stop freezes
    wr(A_CTRL, 32'h0);
    idle(5);
    rd(A_CNT, 32'd3, "R9 frozen after stop");

    // R10 restart from stopped
    wr(A_CNT, 32'd2);
    wr(A_CTRL, 32'h7);
    rd(A_CNT, 32'd3, "R10 restart reloads");
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd2);
    wr(A_CTRL, 32'h1);
    rd(A_CNT, 32'd2, "R10 restart keeps count one-shot");
    wr(A_CTRL, 32'h0);

    // R11 prescaler P=3
    wr(A_STAT, 32'd1);
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, 32'h305);
    idle(3);
    rd(A_CNT, 32'd2, "R11 before first tick");
    rd(A_CNT, 32'd1, "R11 after first tick");
    idle(2);
    chk_irq(1'b0, "R11 before zero");
    idle(1);
    chk_irq(1'b1, "R11 at zero");
    rd(A_CTRL, 32'h305, "R2 ctrl readback");

    idle(3);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2 pending reads actual %0d expected 0", sb.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule